// File: doc/BRIEF.md
# Chained-Stage Wide Unsigned Divider

This block divides an unsigned 32-bit dividend by an unsigned 16-bit divisor. It returns the complete 32-bit quotient and a 16-bit remainder. A plain 32/16 division step can only hold a 16-bit quotient, so the block never makes one direct division. It runs two such steps one after the other, and each step is arranged so that its quotient is sure to fit in 16 bits. No input pair can therefore cause a quotient overflow.

In the first step, the upper half of the dividend is extended with zeros and divided by the divisor. The quotient of that step becomes the upper half of the result. In the second step, the first step's remainder is placed in the upper half of a new 32-bit dividend and the lower half of the original dividend fills the lower half. The quotient of the second step becomes the lower half of the result, and its remainder is the final remainder.

A single iterative restoring shift-subtract core carries out both steps and produces one quotient bit per clock. A small state machine sequences the two steps. The states are `ST_IDLE`, `ST_HIGH` and `ST_LOW`, with these transitions:
- ACCEPT (`ST_IDLE` to `ST_HIGH`): start arrives with a nonzero divisor.
- REJECT_ZERO (`ST_IDLE` to `ST_IDLE`): start arrives with a zero divisor, and the error result is posted.
- CHAIN (`ST_HIGH` to `ST_LOW`): the core finishes the upper step.
- FINISH (`ST_LOW` to `ST_IDLE`): the core finishes the lower step.

The user raises `start` for one clock with the operands on the inputs and then waits for the one-cycle `done` pulse.

Top module: `divw_top`

## Requirements
- R1: While reset is held and after its release, `busy`, `done`, `dz_err`, `quot` and `rem` are all zero.
- R2: For a nonzero divisor, `quot` equals floor(dividend / divisor) over all 32 bits and `rem` equals dividend mod divisor.
- R3: The upper step divides the zero-extended upper dividend half by the divisor, giving `quot[31:16]`. Its remainder forms bits 31:16 of the lower step's dividend, so each step's quotient fits in 16 bits. For example, FFFF0000h / 2 gives 7FFF8000h.
- R4: Dividend 000F4240h with divisor 000Ah gives quotient 000186A0h and remainder 0.
- R5: With a nonzero divisor, `busy` is high from the clock edge that accepts `start` onward. `done` rises, and `busy` falls, on the 34th clock edge after the accepting edge.
- R6: `done` is high for exactly one cycle and is never high together with `busy`.
- R7: A zero divisor makes `done` and `dz_err` high right after the accepting edge, with `quot` and `rem` both zero.
- R8: `start` is ignored while `busy` is high. New operands presented then do not change the result of the division in progress.
- R9: After `done`, `quot`, `rem` and `dz_err` hold their values until the next `start`.
- R10: Boundary operands give exact results. These are dividend 0, 1, FFFFh and FFFFFFFFh, each with divisor 1 and with divisor FFFFh.
- R11: A new accepted division with a nonzero divisor clears `dz_err` after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| dividend | input | 32 | Unsigned dividend, sampled with start |
| divisor | input | 16 | Unsigned divisor, sampled with start |
| quot | output | 32 | Full quotient |
| rem | output | 16 | Final remainder |
| busy | output | 1 | High while a division is running |
| done | output | 1 | One-cycle completion pulse |
| dz_err | output | 1 | Divisor was zero |

## Verification
The core's assertions assume two things about every load: the divisor is nonzero, and the upper half of the step dividend is smaller than the divisor. The controller guarantees both. It turns a zero divisor away before loading, and it feeds the second step only a remainder that the first step has already reduced below the divisor. The stimulus therefore needs no constraint beyond what the ports allow. It sweeps divisors 1 to 64 against fixed and varied dividends, runs boundary pairs and uniform random pairs, and pulses start during busy with conflicting operands so that the ignore rule is exercised.

// File: rtl/divw_pkg.sv
package divw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } divw_state_e;
endpackage

// File: rtl/divw_core.sv
// Restoring shift-subtract core: divides {num_hi, num_lo} by den,
// one quotient bit per clock, W iterations. Requires num_hi < den.
module divw_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] num_hi,
    input  logic [W-1:0] num_lo,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic [W-1:0] rmd,
    output logic         fin
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  part_q;
    logic [W-1:0]  qsh_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic          fin_q;

    logic [W:0]    shifted;
    logic [W:0]    diff;
    logic          fits;

    always_comb begin
        shifted = {part_q, qsh_q[W-1]};
        diff    = shifted - {1'b0, den_q};
        fits    = (shifted >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
            qsh_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            fin_q  <= 1'b0;
        end else if (ld) begin
            part_q <= num_hi;
            qsh_q  <= num_lo;
            den_q  <= den;
            cnt_q  <= CW'(W);
            fin_q  <= 1'b0;
        end else if (cnt_q != '0) begin
            part_q <= fits ? diff[W-1:0] : shifted[W-1:0];
            qsh_q  <= {qsh_q[W-2:0], fits};
            cnt_q  <= cnt_q - CW'(1);
            fin_q  <= (cnt_q == CW'(1));
        end else begin
            fin_q  <= 1'b0;
        end
    end

    assign quo = qsh_q;
    assign rmd = part_q;
    assign fin = fin_q;

    // R3: every step is loaded so that its quotient fits in W bits
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> (num_hi < den) && (den != '0));

    // R2: a finished step leaves a remainder below the divisor
    a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (rmd < den_q));

    // R6: completion of a step is a single-cycle event
    a_r6_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);
endmodule

// File: rtl/divw_ctrl.sv
// Sequencer: runs the upper step, chains its remainder into the lower
// step, and owns the result registers.
module divw_ctrl
    import divw_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic           core_ld,
    output logic [W-1:0]   core_hi,
    output logic [W-1:0]   core_lo,
    output logic [W-1:0]   core_den,
    input  logic [W-1:0]   core_quo,
    input  logic [W-1:0]   core_rmd,
    input  logic           core_fin,
    output logic [2*W-1:0] quot,
    output logic [W-1:0]   rem,
    output logic           busy,
    output logic           done,
    output logic           dz_err
);
    divw_state_e state_q, state_d;

    logic [W-1:0]   lo_q;
    logic [W-1:0]   den_q;
    logic [2*W-1:0] quot_q;
    logic [W-1:0]   rem_q;
    logic           done_q;
    logic           err_q;
    logic           accept;
    logic           zero_div;

    assign accept   = (state_q == ST_IDLE) && start;
    assign zero_div = (divisor == '0);

    // next-state and core steering
    always_comb begin
        state_d  = state_q;
        core_ld  = 1'b0;
        core_hi  = core_rmd;
        core_lo  = lo_q;
        core_den = den_q;
        unique case (state_q)
            ST_IDLE: begin
                core_hi  = '0;
                core_lo  = dividend[2*W-1:W];
                core_den = divisor;
                if (accept && !zero_div) begin
                    core_ld = 1'b1;
                    state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (core_fin) begin
                    core_ld = 1'b1;
                    state_d = ST_LOW;
                end
            end
            ST_LOW: begin
                if (core_fin) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output and operand registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            den_q  <= '0;
            quot_q <= '0;
            rem_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        lo_q   <= dividend[W-1:0];
                        den_q  <= divisor;
                        quot_q <= '0;
                        rem_q  <= '0;
                        err_q  <= zero_div;
                        done_q <= zero_div;
                    end
                end
                ST_HIGH: begin
                    if (core_fin) quot_q[2*W-1:W] <= core_quo;
                end
                ST_LOW: begin
                    if (core_fin) begin
                        quot_q[W-1:0] <= core_quo;
                        rem_q         <= core_rmd;
                        done_q        <= 1'b1;
                    end
                end
                default: done_q <= 1'b0;
            endcase
        end
    end

    assign quot   = quot_q;
    assign rem    = rem_q;
    assign done   = done_q;
    assign dz_err = err_q;
    assign busy   = (state_q != ST_IDLE);

    a_r7_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        accept && zero_div |=> done && dz_err && (quot == '0) && (rem == '0));

    a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !zero_div |=> busy && !done);

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(lo_q) && $stable(den_q));

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(quot) && $stable(rem) && $stable(dz_err));

    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r11_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !zero_div |=> !dz_err);
endmodule

// File: rtl/divw_top.sv
module divw_top #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic [2*W-1:0] quot,
    output logic [W-1:0]   rem,
    output logic           busy,
    output logic           done,
    output logic           dz_err
);
    logic         core_ld;
    logic [W-1:0] core_hi;
    logic [W-1:0] core_lo;
    logic [W-1:0] core_den;
    logic [W-1:0] core_quo;
    logic [W-1:0] core_rmd;
    logic         core_fin;

    divw_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dividend (dividend),
        .divisor  (divisor),
        .core_ld  (core_ld),
        .core_hi  (core_hi),
        .core_lo  (core_lo),
        .core_den (core_den),
        .core_quo (core_quo),
        .core_rmd (core_rmd),
        .core_fin (core_fin),
        .quot     (quot),
        .rem      (rem),
        .busy     (busy),
        .done     (done),
        .dz_err   (dz_err)
    );

    divw_core #(.W(W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (core_ld),
        .num_hi (core_hi),
        .num_lo (core_lo),
        .den    (core_den),
        .quo    (core_quo),
        .rmd    (core_rmd),
        .fin    (core_fin)
    );
endmodule

// File: tb/tb_divw_top.sv
`timescale 1ns/1ps
module tb_divw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic [31:0] quot;
    logic [15:0] rem;
    logic        busy, done, dz_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    divw_top #(.W(16)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .quot(quot), .rem(rem), .busy(busy), .done(done), .dz_err(dz_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // runs one division; poke pulses start mid-run with other operands (R8)
    task automatic run_op(input logic [31:0] x, input logic [15:0] n,
                          input bit poke, input string req);
        logic [31:0] eq;
        logic [15:0] er;
        int cyc = 0;
        bit seen = 0;
        eq = (n == 0) ? 32'd0 : x / {16'd0, n};
        er = (n == 0) ? 16'd0 : 16'(x % {16'd0, n});
        @(negedge clk);
        dividend = x; divisor = n; start = 1'b1;
        while (!seen && cyc < 100) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                start = 1'b0;
                if (n != 0) chk(busy == 1'b1, "R5", "busy after accept", busy, 1);
            end
            if (poke && cyc == 5) begin
                start = 1'b1; dividend = ~x; divisor = (n ^ 16'h5a5a) | 16'd1;
            end
            if (poke && cyc == 6) start = 1'b0;
            if (done) seen = 1;
        end
        chk(seen, req, "done seen", longint'(seen), 1);
        chk((cyc - 1) == ((n == 0) ? 0 : 34), (n == 0) ? "R7" : "R5",
            "edges to done", cyc - 1, (n == 0) ? 0 : 34);
        chk(busy == 1'b0, "R6", "busy with done", busy, 0);
        chk(quot == eq, req, "quotient", quot, eq);
        chk(rem == er, req, "remainder", rem, er);
        chk(dz_err == (n == 0), (n == 0) ? "R7" : "R11", "dz_err", dz_err, (n == 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] sq;
        logic [15:0] sr;
        logic        se;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({busy, done, dz_err} == 3'b000, "R1", "flags in reset", {busy, done, dz_err}, 0);
        chk(quot == 0 && rem == 0, "R1", "results in reset", quot, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, dz_err} == 3'b000, "R1", "flags after reset", {busy, done, dz_err}, 0);

        // R4 worked example
        run_op(32'h000F4240, 16'h000A, 0, "R4");

        // R10 boundary operands
        foreach (sq[i]) begin end
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 2; b++) begin
                logic [31:0] xv;
                xv = (a == 0) ? 32'd0 : (a == 1) ? 32'd1 : (a == 2) ? 32'h0000FFFF : 32'hFFFFFFFF;
                run_op(xv, (b == 0) ? 16'd1 : 16'hFFFF, 0, "R10");
            end
        end

        // R3 upper step: explicit high-half check
        run_op(32'hFFFF0000, 16'd2, 0, "R3");
        chk(quot[31:16] == 16'h7FFF, "R3", "upper quotient half", quot[31:16], 16'h7FFF);
        run_op(32'h12345678, 16'h0123, 0, "R3");
        chk(quot[31:16] == 16'(16'h1234 / 16'h0123), "R3", "upper quotient half",
            quot[31:16], 16'h1234 / 16'h0123);

        // R7 zero divisor, then R11 clear on next job
        run_op(32'hFFFFFFFF, 16'd0, 0, "R7");
        run_op(32'h00000000, 16'd0, 0, "R7");
        run_op(32'h89ABCDEF, 16'd7, 0, "R11");

        // R9 hold and R6 single pulse
        run_op(32'hCAFEF00D, 16'h0BAD, 0, "R2");
        sq = quot; sr = rem; se = dz_err;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(done == 1'b0, "R6", "done after pulse", done, 0);
            chk(quot == sq && rem == sr && dz_err == se, "R9", "result held", quot, sq);
        end
        dividend = 32'h11111111; divisor = 16'h2222;
        repeat (2) @(negedge clk);
        chk(quot == sq && rem == sr, "R9", "held under input change", quot, sq);

        // R8 start ignored while busy
        run_op(32'hDEADBEEF, 16'h0031, 1, "R8");
        run_op(32'h00000005, 16'hFFFF, 1, "R8");
        run_op(32'hFFFFFFFF, 16'h0003, 1, "R8");

        // R2 divisor sweep
        for (int n = 1; n <= 64; n++) begin
            run_op(32'hFFFFFFFF - 32'(n * 977), 16'(n), 0, "R2");
            run_op(32'(n) * 32'h01010101, 16'(n), 0, "R2");
        end
        // R2 random operands
        for (int k = 0; k < 300; k++) begin
            logic [31:0] rx;
            logic [15:0] rn;
            rx = $urandom;
            rn = (k % 3 == 0) ? 16'(($urandom % 16) + 1) : 16'($urandom);
            if (rn == 0) rn = 16'd1;
            run_op(rx, rn, 0, "R2");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule